// File: doc/BRIEF.md
# I2C Arbitration and Address-Status Monitor

This block sits beside the shift and clock logic of an I2C controller. It watches the two bus lines and keeps the status bits that such a controller reports. The SCL and SDA pins pass through two-flop synchronizers. Start and stop conditions and SCL edges are found in the system clock domain. A bit counter then tracks the position of each bus clock within the byte.

While the controller acts as master, every rising SCL edge compares the line with the controller's own SDA drive. If they differ, arbitration is lost. A one-cycle pulse then tells the controller to drop to slave receiver. SDA is held released until the byte ends, and the losing master's clock is held stopped after that byte.

For the slave side, the block decides whether it is addressed, either by own-address match or by general call, or, with address recognition off, once the first data byte is in. It also flags a general call and keeps the SDA value from the most recent rising SCL edge. A one-cycle byte-complete pulse follows the acknowledge clock. Register-access strobes from the controller clear the flags.

Top module: `i2c_arb_monitor`

## Requirements
- R1: Arbitration lost (`arb_lost`) sets on a synchronized SCL rising edge when `mst_i` is 1, `sda_release` is 0, and the synchronized SDA line differs from `sda_drv`. This compare runs on every clock when `trx_i` is 1, and only on the ninth (acknowledge) clock when `trx_i` is 0.
- R2: In the cycle `arb_lost` rises, `mode_drop` is 1 for exactly that cycle and `sda_release` becomes 1.
- R3: A one-cycle pulse on `dbr_rd`, `dbr_wr` or `cr2_wr` clears `arb_lost`. A new loss in the same cycle wins over the clear.
- R4: With `addr_rec_off` = 0 and `mst_i` = 0, `slave_hit` sets on the eighth rising SCL edge after a start if the received byte, taken MSB first, is all zero or its upper seven bits equal `own_addr`. A matching byte received while `mst_i` = 1 and no loss is pending leaves it at 0.
- R5: With `addr_rec_off` = 1, the address byte is ignored, and `slave_hit` sets on the eighth rising SCL edge of the second byte after a start.
- R6: `slave_hit` clears on a `dbr_rd` or `dbr_wr` pulse. `cr2_wr` leaves it unchanged.
- R7: `gen_call` sets when the first byte after a start is all zero, received as a slave. It clears on the next start or stop condition.
- R8: `last_bit` holds the SDA value sampled at the latest SCL rising edge. After the ninth clock it therefore equals the acknowledge bit.
- R9: `byte_irq` is a one-cycle pulse, once per byte, raised on the SCL falling edge that ends the ninth clock.
- R10: `sda_release` stays 1 until the SCL falling edge that ends the ninth clock, or until a start or stop condition. At that byte end `scl_stop` sets. `scl_stop` clears on `dbr_rd`, `dbr_wr`, `cr2_wr`, start or stop.
- R11: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one resets the bit count and the byte number.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL bus line, asynchronous |
| sda_in | input | 1 | SDA bus line, asynchronous |
| sda_drv | input | 1 | Controller's own SDA drive level (1 = released) |
| mst_i | input | 1 | Controller is master |
| trx_i | input | 1 | Controller is transmitter |
| addr_rec_off | input | 1 | 1 = address recognition off (free-data mode) |
| own_addr | input | ADDR_W | Own slave address |
| dbr_rd | input | 1 | Data register read strobe |
| dbr_wr | input | 1 | Data register write strobe |
| cr2_wr | input | 1 | Second control register write strobe |
| arb_lost | output | 1 | Arbitration lost flag |
| slave_hit | output | 1 | Addressed-as-slave flag |
| gen_call | output | 1 | General call received flag |
| last_bit | output | 1 | Last sampled SDA bit |
| mode_drop | output | 1 | Pulse: clear master and transmit bits |
| sda_release | output | 1 | Hold SDA drive high for rest of byte |
| scl_stop | output | 1 | Hold own SCL output after lost byte |
| byte_irq | output | 1 | Byte-complete pulse |

## Verification
A pin change passes two synchronizer flops and then an edge-detect compare before the flag register loads. Every flag therefore reflects a bus event on the third rising clock edge after the pin moves. The strobes act on the next edge. The bench holds each bus level for four clocks and samples on the falling clock edge after that, so every flag has settled and no check lands on the edge where it changes. The single-cycle pulses (`byte_irq`, `mode_drop`) are counted on every falling edge, and the counts are compared after each byte.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } bus_ev_t;

  function automatic int unsigned cnt_width(input int unsigned byte_w);
    return $clog2(byte_w + 2);
  endfunction
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb st_d = {st_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_bus_cond.sv
module i2c_mon_bus_cond
  import i2c_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    ev.scl_rise = scl_s & ~scl_p;
    ev.scl_fall = ~scl_s & scl_p;
    ev.start    = scl_s & scl_p & sda_p & ~sda_s;
    ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
  end
endmodule

// File: rtl/i2c_mon_bit_track.sv
module i2c_mon_bit_track
  import i2c_mon_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CW    = cnt_width(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic              sda_s,
  output logic [CW-1:0]     rise_idx,
  output logic [BYTE_W-1:0] byte_val,
  output logic [1:0]        byte_no,
  output logic              byte_end
);
  localparam logic [CW-1:0] ACK_IDX = CW'(BYTE_W + 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [1:0]        bno_q, bno_d;
  logic              cnt_en, sh_en, bno_en;

  always_comb begin
    rise_idx = (cnt_q == ACK_IDX) ? CW'(1) : cnt_q + CW'(1);
    byte_val = {sh_q, sda_s};
    byte_end = ev.scl_fall && (cnt_q == ACK_IDX);

    cnt_en = ev.start | ev.stop | ev.scl_rise;
    cnt_d  = (ev.start | ev.stop) ? '0 : rise_idx;

    sh_en  = ev.scl_rise && (rise_idx <= CW'(BYTE_W));
    sh_d   = byte_val[BYTE_W-2:0];

    bno_en = ev.start | ev.stop | (byte_end && (bno_q != 2'd2));
    bno_d  = (ev.start | ev.stop) ? 2'd0 : bno_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      bno_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (sh_en)  sh_q  <= sh_d;
      if (bno_en) bno_q <= bno_d;
    end
  end

  assign byte_no = bno_q;
endmodule

// File: rtl/i2c_mon_flags.sv
module i2c_mon_flags
  import i2c_mon_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CW     = cnt_width(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic              sda_s,
  input  logic              sda_drv,
  input  logic              mst_i,
  input  logic              trx_i,
  input  logic              addr_rec_off,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [CW-1:0]     rise_idx,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [1:0]        byte_no,
  input  logic              byte_end,
  input  logic              dbr_rd,
  input  logic              dbr_wr,
  input  logic              cr2_wr,
  output logic              arb_lost,
  output logic              slave_hit,
  output logic              gen_call,
  output logic              last_bit,
  output logic              mode_drop,
  output logic              sda_release,
  output logic              scl_stop,
  output logic              byte_irq
);
  localparam logic [CW-1:0] ACK_IDX  = CW'(BYTE_W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(BYTE_W);

  logic al_q, al_d, aas_q, aas_d, gc_q, gc_d, lrb_q, lrb_d;
  logic rel_q, rel_d, stp_q, stp_d, drop_q, irq_q;
  logic cmp_en, al_set, acc_clr, dbr_acc, bus_cond;
  logic slave, addr_done, data1_done, zero_byte, addr_eq, aas_set, gc_set;

  always_comb begin
    bus_cond = ev.start | ev.stop;
    dbr_acc  = dbr_rd | dbr_wr;
    acc_clr  = dbr_acc | cr2_wr;

    cmp_en = ev.scl_rise && mst_i && !rel_q && (trx_i || (rise_idx == ACK_IDX));
    al_set = cmp_en && (sda_s != sda_drv);
    al_d   = al_set ? 1'b1 : (acc_clr ? 1'b0 : al_q);

    rel_d  = al_set ? 1'b1 : ((byte_end | bus_cond) ? 1'b0 : rel_q);
    stp_d  = (byte_end && rel_q) ? 1'b1 : ((acc_clr | bus_cond) ? 1'b0 : stp_q);

    slave      = !mst_i || rel_q;
    addr_done  = ev.scl_rise && (rise_idx == LAST_IDX) && (byte_no == 2'd0);
    data1_done = ev.scl_rise && (rise_idx == LAST_IDX) && (byte_no == 2'd1);
    zero_byte  = (byte_val == '0);
    addr_eq    = (byte_val[BYTE_W-1:1] == own_addr);

    aas_set = slave && (addr_rec_off ? data1_done : (addr_done && (zero_byte || addr_eq)));
    aas_d   = aas_set ? 1'b1 : (dbr_acc ? 1'b0 : aas_q);

    gc_set  = slave && addr_done && zero_byte;
    gc_d    = gc_set ? 1'b1 : (bus_cond ? 1'b0 : gc_q);

    lrb_d   = ev.scl_rise ? sda_s : lrb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q   <= 1'b0;
      aas_q  <= 1'b0;
      gc_q   <= 1'b0;
      lrb_q  <= 1'b0;
      rel_q  <= 1'b0;
      stp_q  <= 1'b0;
      drop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      al_q   <= al_d;
      aas_q  <= aas_d;
      gc_q   <= gc_d;
      lrb_q  <= lrb_d;
      rel_q  <= rel_d;
      stp_q  <= stp_d;
      drop_q <= al_set;
      irq_q  <= byte_end;
    end
  end

  assign arb_lost    = al_q;
  assign slave_hit   = aas_q;
  assign gen_call    = gc_q;
  assign last_bit    = lrb_q;
  assign mode_drop   = drop_q;
  assign sda_release = rel_q;
  assign scl_stop    = stp_q;
  assign byte_irq    = irq_q;
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_mon_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              sda_drv,
  input  logic              mst_i,
  input  logic              trx_i,
  input  logic              addr_rec_off,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              dbr_rd,
  input  logic              dbr_wr,
  input  logic              cr2_wr,
  output logic              arb_lost,
  output logic              slave_hit,
  output logic              gen_call,
  output logic              last_bit,
  output logic              mode_drop,
  output logic              sda_release,
  output logic              scl_stop,
  output logic              byte_irq
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CW     = cnt_width(BYTE_W);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_s;
  logic              scl_s, sda_s;
  bus_ev_t           bus_ev;
  logic [CW-1:0]     rise_idx;
  logic [BYTE_W-1:0] byte_val;
  logic [1:0]        byte_no;
  logic              byte_end;

  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
    );
  end

  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2c_mon_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .ev(bus_ev)
  );

  i2c_mon_bit_track #(.BYTE_W(BYTE_W)) u_track (
    .clk(clk), .rst_n(rst_n), .ev(bus_ev), .sda_s(sda_s),
    .rise_idx(rise_idx), .byte_val(byte_val), .byte_no(byte_no), .byte_end(byte_end)
  );

  i2c_mon_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev(bus_ev), .sda_s(sda_s), .sda_drv(sda_drv),
    .mst_i(mst_i), .trx_i(trx_i), .addr_rec_off(addr_rec_off), .own_addr(own_addr),
    .rise_idx(rise_idx), .byte_val(byte_val), .byte_no(byte_no), .byte_end(byte_end),
    .dbr_rd(dbr_rd), .dbr_wr(dbr_wr), .cr2_wr(cr2_wr),
    .arb_lost(arb_lost), .slave_hit(slave_hit), .gen_call(gen_call), .last_bit(last_bit),
    .mode_drop(mode_drop), .sda_release(sda_release), .scl_stop(scl_stop), .byte_irq(byte_irq)
  );
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic mst_i,
  input logic addr_rec_off,
  input logic dbr_rd,
  input logic dbr_wr,
  input logic cr2_wr,
  input logic start_ev,
  input logic stop_ev,
  input logic arb_lost,
  input logic slave_hit,
  input logic gen_call,
  input logic mode_drop,
  input logic sda_release,
  input logic scl_stop,
  input logic byte_irq
);
  AST_AL_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(mst_i)); // R1
  AST_AL_FORCES_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (mode_drop && sda_release)); // R2
  AST_AL_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_lost) |-> $past(dbr_rd || dbr_wr || cr2_wr)); // R3
  AST_GC_MARKS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gen_call) && $past(!addr_rec_off)) |-> slave_hit); // R4
  AST_AAS_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slave_hit) |-> $past(dbr_rd || dbr_wr)); // R6
  AST_GC_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_call) |-> $past(start_ev || stop_ev)); // R7
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |=> !byte_irq); // R9
  AST_STOP_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_stop) |-> $past(sda_release)); // R10
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mst_i(mst_i), .addr_rec_off(addr_rec_off),
  .dbr_rd(dbr_rd), .dbr_wr(dbr_wr), .cr2_wr(cr2_wr),
  .start_ev(bus_ev.start), .stop_ev(bus_ev.stop),
  .arb_lost(arb_lost), .slave_hit(slave_hit), .gen_call(gen_call),
  .mode_drop(mode_drop), .sda_release(sda_release), .scl_stop(scl_stop),
  .byte_irq(byte_irq)
);

// File: tb/test_i2c_arb_monitor.sv
`timescale 1ns/1ps
module test_i2c_arb_monitor;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, sda_drv = 1'b1;
  logic mst_i = 1'b0, trx_i = 1'b0, addr_rec_off = 1'b0;
  logic [ADDR_W-1:0] own_addr = '0;
  logic dbr_rd = 1'b0, dbr_wr = 1'b0, cr2_wr = 1'b0;
  logic arb_lost, slave_hit, gen_call, last_bit, mode_drop, sda_release, scl_stop, byte_irq;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int drop_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_arb_monitor #(.ADDR_W(ADDR_W)) i_i2c_arb_monitor (.*);

  always @(negedge clk) begin
    if (byte_irq)  irq_cnt++;
    if (mode_drop) drop_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic d);
    @(negedge clk);
    scl_in = s;
    sda_in = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start();
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  task automatic send_bit(input logic b);
    step(1'b0, b);
    step(1'b1, b);
    step(1'b0, b);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  typedef enum int {P_RD, P_WR, P_CR2} strobe_e;
  task automatic pulse(input strobe_e which);
    @(negedge clk);
    case (which)
      P_RD:  dbr_rd = 1'b1;
      P_WR:  dbr_wr = 1'b1;
      default: cr2_wr = 1'b1;
    endcase
    @(negedge clk);
    dbr_rd = 1'b0; dbr_wr = 1'b0; cr2_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic bit exp_hit(input logic [7:0] v, input logic [ADDR_W-1:0] own);
    return (v == 8'h00) || (v[7:1] == own);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int irq0;
    logic [7:0] v;
    logic ack;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    check("R12 outputs", {arb_lost, slave_hit, gen_call, last_bit,
                          mode_drop, sda_release, scl_stop, byte_irq}, 0);

    // R1 R2 R10 R3: transmit master loses at the seventh bit
    own_addr = 7'h11; mst_i = 1'b1; trx_i = 1'b1;
    do_start();
    begin
      logic [7:0] line_b = 8'hA5, drv_b = 8'hA7;
      for (int i = 7; i >= 0; i--) begin
        sda_drv = drv_b[i];
        send_bit(line_b[i]);
        if (i == 2) check("R1 no loss while equal", arb_lost, 0);
        if (i == 1) begin
          check("R1 loss on mismatch", arb_lost, 1);
          check("R2 mode_drop pulse", drop_cnt, 1);
          check("R2 sda_release", sda_release, 1);
          mst_i = 1'b0; trx_i = 1'b0;
        end
      end
    end
    sda_drv = 1'b1;
    irq0 = irq_cnt;
    send_bit(1'b1);
    check("R10 release ends", sda_release, 0);
    check("R10 scl_stop set", scl_stop, 1);
    check("R9 irq once", irq_cnt - irq0, 1);
    check("R4 no address match", slave_hit, 0);
    pulse(P_CR2);
    check("R3 cr2 clears loss", arb_lost, 0);
    check("R10 scl_stop cleared", scl_stop, 0);
    do_stop();

    // R1 R4: receiving master, data-bit mismatch ignored, match not taken
    mst_i = 1'b1; trx_i = 1'b0;
    do_start();
    sda_drv = 1'b1;
    send_byte({7'h11, 1'b0});
    check("R1 receive data not compared", arb_lost, 0);
    sda_drv = 1'b0;
    send_bit(1'b0);
    sda_drv = 1'b1;
    check("R4 master not addressed", slave_hit, 0);
    check("R8 ack bit", last_bit, 0);
    do_stop();
    mst_i = 1'b0;

    // R1 R3: receiving master loses on ack clock, data read clears
    mst_i = 1'b1; trx_i = 1'b0;
    do_start();
    send_byte(8'h3C);
    sda_drv = 1'b0;
    send_bit(1'b1);
    sda_drv = 1'b1;
    check("R1 ack mismatch", arb_lost, 1);
    mst_i = 1'b0;
    pulse(P_RD);
    check("R3 read clears loss", arb_lost, 0);
    do_stop();

    // R5: free-data mode
    addr_rec_off = 1'b1;
    do_start();
    send_byte({7'h11, 1'b0});
    send_bit(1'b0);
    check("R5 address ignored", slave_hit, 0);
    send_byte(8'h5A);
    check("R5 first data byte", slave_hit, 1);
    send_bit(1'b0);
    pulse(P_WR);
    check("R6 write clears", slave_hit, 0);
    do_stop();
    addr_rec_off = 1'b0;

    // R11: repeated start restarts byte count
    do_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    step(1'b0, 1'b1);
    do_start();
    send_byte(8'h00);
    check("R11 restart aligns count", gen_call, 1);
    send_bit(1'b0);
    pulse(P_RD);
    do_start();
    check("R7 start clears gc", gen_call, 0);
    do_stop();

    // Random address bytes: R4 R6 R7 R8 R9
    for (int it = 0; it < 40; it++) begin
      own_addr = ADDR_W'($urandom);
      case ($urandom % 3)
        0: v = 8'h00;
        1: v = {own_addr, 1'($urandom)};
        default: v = 8'($urandom);
      endcase
      ack = 1'($urandom);
      do_start();
      send_byte(v);
      irq0 = irq_cnt;
      send_bit(ack);
      check("R4 match", slave_hit, int'(exp_hit(v, own_addr)));
      check("R7 general call", gen_call, int'(v == 8'h00));
      check("R8 last bit", last_bit, int'(ack));
      check("R9 irq count", irq_cnt - irq0, 1);
      pulse(P_CR2);
      check("R6 cr2 no effect", slave_hit, int'(exp_hit(v, own_addr)));
      pulse(($urandom % 2) ? P_RD : P_WR);
      check("R6 access clears", slave_hit, 0);
      do_stop();
      check("R7 stop clears gc", gen_call, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule